// File: doc/BRIEF.md
# I2C Target Receive DMA Controller

This block is the receive side of an I2C bus controller acting as a target in packet mode. A byte-level bus front end reports start conditions with the received address, data bytes and stop conditions. When the address matches the programmed own address and both enables are set, incoming bytes are written through a byte-wide memory port. The write address counter advances and the remaining-length counter counts down with each byte. A received-byte count field records how many bytes the transfer delivered.

A transfer that ends with a normal stop sets a group of four completion status bits at once. Software clears all four with a single write to the packet-done bit. One drop bit sits above that group and is cleared on its own. Each status bit is masked by an enable bit before it can request an interrupt. The interrupt line is shared with the controller (master) side of the same bus controller. The target side does not take the line while controller status is pending, and it takes the line back as soon as that status goes away.

Top module: `i2c_tgt_rxdma`

Registers, by word index on `reg_idx`:

| Index | Contents |
|---|---|
| 0 | Own address in [6:0] |
| 1 | Controller enable in bit 0, target enable in bit 1 |
| 2 | RX DMA enable in bit 0 |
| 3 | Current DMA address |
| 4 | Remaining length in [LW-1:0], received count in [16+LW-1:16], write-enable for the count in bit 31 |
| 5 | Status |
| 6 | Interrupt enable, same layout as status |

Status bit positions are: 0 address matched, 1 stop seen, 2 receive direction, 3 packet done, 4 byte dropped.

## Requirements
- R1: After reset every register reads 0, and `irq`, `irq_tgt` and `mem_we` are low.
- R2: A start whose address equals the own address (index 0), with both enables at index 1 set, resets the received-count field of index 4 to zero before any byte arrives.
- R3: Each byte of a matched transfer, with RX DMA enabled and a nonzero remaining length, is written to the current DMA address. The address then increments by one, the remaining length decrements by one and the received count increments by one.
- R4: A byte that arrives while the remaining length is zero is not written and moves no counter, and it sets status bit 4.
- R5: A start with a non-matching address is ignored: no byte of that transfer is written and no status bit is set.
- R6: A stop that ends a matched transfer sets status bits 3, 2, 1 and 0 together.
- R7: Writing 1 to status bit 3 clears bits 3 to 0 and leaves bit 4. Writing 1 to bit 4 clears bit 4. Writing 1 only to bits 2 to 0 changes nothing.
- R8: A write to index 4 always loads the remaining length. It loads the received-count field only when bit 31 of the written data is 1.
- R9: The target requests an interrupt only when some status bit and the matching bit of index 6 are both 1.
- R10: `irq` goes high one cycle after `ctl_pend` or the target request is high. `irq_tgt` is high only while the target requests and `ctl_pend` was low in the previous cycle, so the target reasserts once `ctl_pend` falls.
- R11: With RX DMA disabled (index 2 bit 0 = 0), received bytes are not written and move no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data returned next cycle |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| fe_start | input | 1 | Start plus address byte received |
| fe_addr | input | 7 | Received 7-bit address |
| fe_byte_vld | input | 1 | Data byte received |
| fe_byte | input | 8 | Data byte value |
| fe_stop | input | 1 | Normal stop received |
| ctl_pend | input | 1 | Controller-side interrupt status pending |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq | output | 1 | Shared interrupt line |
| irq_tgt | output | 1 | Target side currently drives the line |

## Verification
A counter that slips shows up at the memory port on the very next byte, as a write to the wrong address or an extra write. It also shows in the address and length readback as soon as the transfer ends. A status group that fails to set or clear as a unit shows in the status readback and in `irq` within two cycles of the stop or the clearing write. Faulty sharing of the line shows as `irq_tgt` being high in the cycle after `ctl_pend` was high, or as `irq_tgt` staying low after `ctl_pend` falls.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int IDX_W = 3;
  localparam int ST_W  = 5;
  localparam int ST_MATCH = 0;
  localparam int ST_STOP  = 1;
  localparam int ST_RX    = 2;
  localparam int ST_PKT   = 3;
  localparam int ST_DROP  = 4;
  localparam int CNT_LSB  = 16;
  localparam int CNT_WE   = 31;

  typedef enum logic [IDX_W-1:0] {
    RI_OWN  = 3'd0,
    RI_FUNC = 3'd1,
    RI_CMD  = 3'd2,
    RI_BASE = 3'd3,
    RI_LEN  = 3'd4,
    RI_STS  = 3'd5,
    RI_IEN  = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic start_ok;
    logic take;
    logic drop;
    logic done;
  } rx_evt_t;
endpackage

// File: rtl/tgt_rx_fsm.sv
module tgt_rx_fsm
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_en,
  input  logic       tgt_en,
  input  logic       dma_en,
  input  logic [6:0] own_addr,
  input  logic       room,
  input  logic       fe_start,
  input  logic [6:0] fe_addr,
  input  logic       fe_byte_vld,
  input  logic       fe_stop,
  output rx_evt_t    evt
);
  typedef enum logic {S_IDLE, S_RECV} rx_state_e;
  rx_state_e state_q, state_d;

  logic hit;
  assign hit = fe_start && ctl_en && tgt_en && (fe_addr == own_addr);

  always_comb begin
    evt      = '0;
    state_d  = state_q;
    evt.start_ok = hit;
    if (fe_start) begin
      state_d = hit ? S_RECV : S_IDLE;
    end else if (state_q == S_RECV) begin
      evt.take = fe_byte_vld && dma_en && room;
      evt.drop = fe_byte_vld && dma_en && !room;
      if (fe_stop) begin
        evt.done = 1'b1;
        state_d  = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/tgt_dma_ctr.sv
module tgt_dma_ctr
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  rx_evt_t       evt,
  input  logic [7:0]    fe_byte,
  input  logic          wr_base,
  input  logic          wr_len,
  input  logic          wr_cnt,
  input  logic [AW-1:0] base_in,
  input  logic [LW-1:0] len_in,
  input  logic [LW-1:0] cnt_in,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] remain,
  output logic [LW-1:0] rx_cnt,
  output logic          room,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  assign room = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      remain    <= '0;
      rx_cnt    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (evt.take) begin
        mem_we    <= 1'b1;
        mem_addr  <= cur_addr;
        mem_wdata <= fe_byte;
        cur_addr  <= cur_addr + 1'b1;
        remain    <= remain - 1'b1;
        rx_cnt    <= rx_cnt + 1'b1;
      end else begin
        if (wr_base) cur_addr <= base_in;
        if (wr_len)  remain   <= len_in;
        if (evt.start_ok)  rx_cnt <= '0;
        else if (wr_cnt)   rx_cnt <= cnt_in;
      end
    end
  end
endmodule

// File: rtl/tgt_irq_share.sv
module tgt_irq_share
  import i2c_tgt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  rx_evt_t         evt,
  input  logic            sts_wr,
  input  logic [ST_W-1:0] sts_wdata,
  input  logic [ST_W-1:0] ien,
  input  logic            ctl_pend,
  output logic [ST_W-1:0] sts,
  output logic            irq,
  output logic            irq_tgt
);
  logic [ST_W-1:0] sts_d;
  logic            tgt_req;

  always_comb begin
    sts_d = sts;
    if (sts_wr && sts_wdata[ST_PKT]) sts_d[ST_PKT:0] = '0;
    if (sts_wr && sts_wdata[ST_DROP]) sts_d[ST_DROP] = 1'b0;
    if (evt.done) begin
      sts_d[ST_MATCH] = 1'b1;
      sts_d[ST_STOP]  = 1'b1;
      sts_d[ST_RX]    = 1'b1;
      sts_d[ST_PKT]   = 1'b1;
    end
    if (evt.drop) sts_d[ST_DROP] = 1'b1;
  end

  assign tgt_req = |(sts & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts     <= '0;
      irq     <= 1'b0;
      irq_tgt <= 1'b0;
    end else begin
      sts     <= sts_d;
      irq_tgt <= tgt_req && !ctl_pend;
      irq     <= ctl_pend || tgt_req;
    end
  end
endmodule

// File: rtl/i2c_tgt_rxdma.sv
module i2c_tgt_rxdma
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             fe_start,
  input  logic [6:0]       fe_addr,
  input  logic             fe_byte_vld,
  input  logic [7:0]       fe_byte,
  input  logic             fe_stop,
  input  logic             ctl_pend,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             irq,
  output logic             irq_tgt
);
  logic [6:0]      own_q;
  logic [1:0]      func_q;
  logic            cmd_q;
  logic [ST_W-1:0] ien_q;
  logic [ST_W-1:0] sts_q;
  logic [AW-1:0]   cur_addr;
  logic [LW-1:0]   remain;
  logic [LW-1:0]   rx_cnt;
  logic            room;
  rx_evt_t         evt;
  logic [31:0]     rd_d;
  logic            wr_base, wr_len, wr_sts;

  wire unused_wdata = &{1'b0, reg_wdata};

  assign wr_base = reg_wr && (reg_idx == RI_BASE);
  assign wr_len  = reg_wr && (reg_idx == RI_LEN);
  assign wr_sts  = reg_wr && (reg_idx == RI_STS);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= '0;
      func_q <= '0;
      cmd_q  <= 1'b0;
      ien_q  <= '0;
    end else if (reg_wr) begin
      case (reg_idx)
        RI_OWN:  own_q  <= reg_wdata[6:0];
        RI_FUNC: func_q <= reg_wdata[1:0];
        RI_CMD:  cmd_q  <= reg_wdata[0];
        RI_IEN:  ien_q  <= reg_wdata[ST_W-1:0];
        default: ;
      endcase
    end
  end

  tgt_rx_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ctl_en     (func_q[0]),
    .tgt_en     (func_q[1]),
    .dma_en     (cmd_q),
    .own_addr   (own_q),
    .room       (room),
    .fe_start   (fe_start),
    .fe_addr    (fe_addr),
    .fe_byte_vld(fe_byte_vld),
    .fe_stop    (fe_stop),
    .evt        (evt)
  );

  tgt_dma_ctr #(.AW(AW), .LW(LW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .fe_byte  (fe_byte),
    .wr_base  (wr_base),
    .wr_len   (wr_len),
    .wr_cnt   (wr_len && reg_wdata[CNT_WE]),
    .base_in  (reg_wdata[AW-1:0]),
    .len_in   (reg_wdata[LW-1:0]),
    .cnt_in   (reg_wdata[CNT_LSB +: LW]),
    .cur_addr (cur_addr),
    .remain   (remain),
    .rx_cnt   (rx_cnt),
    .room     (room),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  tgt_irq_share u_irq (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .sts_wr   (wr_sts),
    .sts_wdata(reg_wdata[ST_W-1:0]),
    .ien      (ien_q),
    .ctl_pend (ctl_pend),
    .sts      (sts_q),
    .irq      (irq),
    .irq_tgt  (irq_tgt)
  );

  always_comb begin
    rd_d = '0;
    case (reg_idx)
      RI_OWN:  rd_d[6:0] = own_q;
      RI_FUNC: rd_d[1:0] = func_q;
      RI_CMD:  rd_d[0]   = cmd_q;
      RI_BASE: rd_d[AW-1:0] = cur_addr;
      RI_LEN: begin
        rd_d[LW-1:0]          = remain;
        rd_d[CNT_LSB +: LW]   = rx_cnt;
      end
      RI_STS:  rd_d[ST_W-1:0] = sts_q;
      RI_IEN:  rd_d[ST_W-1:0] = ien_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_d;
  end
endmodule

// File: rtl/i2c_tgt_rxdma_chk.sv
module i2c_tgt_rxdma_chk
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_pend,
  input logic            fe_byte_vld,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            irq,
  input logic            irq_tgt,
  input logic [ST_W-1:0] sts_q,
  input logic [ST_W-1:0] ien_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq && !irq_tgt && !mem_we));

  // R3
  write_from_byte_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(fe_byte_vld));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R6
  group_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q[ST_PKT]) |-> (sts_q[ST_RX:ST_MATCH] == 3'b111));

  // R9
  gated_req_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tgt |-> $past(|(sts_q & ien_q)));

  // R10
  yield_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tgt |-> !$past(ctl_pend));

  // R10
  ctl_drives_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_pend) |-> irq);
endmodule

bind i2c_tgt_rxdma i2c_tgt_rxdma_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_i2c_tgt_rxdma.sv
`timescale 1ns/1ps
module tb_i2c_tgt_rxdma;
  localparam int AW = 10;
  localparam int LW = 12;
  localparam logic [6:0] OWN = 7'h3A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        fe_start = 0, fe_byte_vld = 0, fe_stop = 0, ctl_pend = 0;
  logic [6:0]  fe_addr = 0;
  logic [7:0]  fe_byte = 0;
  logic        mem_we, irq, irq_tgt;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, errors = 0, wcount = 0;
  logic [7:0] mem [0:(1<<AW)-1];

  always #2 clk = ~clk;

  i2c_tgt_rxdma #(.AW(AW), .LW(LW)) dut (.*);

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    wcount <= wcount + 1;
  end

  // {addr, buffer length, byte count, first byte}
  localparam int NV = 4;
  localparam logic [34:0] VEC [NV] = '{
    {7'h3A, 12'd8, 8'd5, 8'h10},
    {7'h3A, 12'd3, 8'd6, 8'hA0},
    {7'h15, 12'd4, 8'd2, 8'h55},
    {7'h3A, 12'd1, 8'd1, 8'hF0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = idx[2:0]; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_idx = idx[2:0];
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic bus_start(input logic [6:0] a);
    @(negedge clk); fe_start = 1; fe_addr = a;
    @(negedge clk); fe_start = 0;
  endtask

  task automatic bus_byte(input logic [7:0] b);
    @(negedge clk); fe_byte_vld = 1; fe_byte = b;
    @(negedge clk); fe_byte_vld = 0;
  endtask

  task automatic bus_stop();
    @(negedge clk); fe_stop = 1;
    @(negedge clk); fe_stop = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk("R1 irq", {30'd0, irq, irq_tgt}, 0);
    chk("R1 mem_we", {31'd0, mem_we}, 0);
    for (int i = 0; i < 7; i++) begin
      rd(i, d);
      chk("R1 reg", d, 0);
    end

    wr(0, OWN);
    wr(1, 3);
    wr(2, 1);
    wr(6, 0);

    // table walk: R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [6:0]  a;
      logic [11:0] bl;
      logic [7:0]  n, b0;
      int base, stored, w0;
      logic match;
      {a, bl, n, b0} = VEC[v];
      base  = 32 + 16 * v;
      match = (a == OWN);
      stored = !match ? 0 : (int'(n) < int'(bl) ? int'(n) : int'(bl));
      wr(5, 32'h18);
      wr(3, base);
      wr(4, 32'h8000_0000 | bl);
      w0 = wcount;
      bus_start(a);
      for (int k = 0; k < n; k++) bus_byte(b0 + k[7:0]);
      bus_stop();
      idle(2);
      rd(3, d);
      chk("R3/R5 address", d, base + stored);
      rd(4, d);
      chk("R3/R8 length", d, ((bl - stored) & 32'hFFF) | (stored << 16));
      rd(5, d);
      chk("R4/R5/R6 status", d, !match ? 0 : (32'hF | ((n > bl) ? 32'h10 : 0)));
      chk("R3/R4 writes", wcount - w0, stored);
      for (int k = 0; k < stored; k++)
        chk("R3 data", {24'd0, mem[base + k]}, {24'd0, b0 + k[7:0]});
    end

    // R2 received count reset at start, before bytes
    wr(4, 32'h8007_0005);
    rd(4, d);
    chk("R8 count loaded", d, 32'h0007_0005);
    bus_start(OWN);
    rd(4, d);
    chk("R2 count cleared", d, 32'h0000_0005);
    bus_stop();

    // R8 without write-enable: count kept, remaining loaded
    bus_start(OWN);
    bus_byte(8'h11);
    bus_stop();
    wr(4, 32'h0055_0009);
    rd(4, d);
    chk("R8 count kept", d, 32'h0001_0009);

    // R7 grouped clear
    wr(4, 0);
    bus_start(OWN);
    bus_byte(8'h22);
    bus_stop();
    rd(5, d);
    chk("R4 drop set", d, 32'h1F);
    wr(5, 32'h07);
    rd(5, d);
    chk("R7 low bits no effect", d, 32'h1F);
    wr(5, 32'h08);
    rd(5, d);
    chk("R7 group clear", d, 32'h10);
    wr(5, 32'h10);
    rd(5, d);
    chk("R7 drop clear", d, 0);

    // R9 masking
    bus_start(OWN);
    bus_stop();
    idle(2);
    chk("R9 masked", {30'd0, irq, irq_tgt}, 0);
    wr(6, 32'h08);
    idle(2);
    chk("R9 enabled", {30'd0, irq, irq_tgt}, 32'h3);

    // R10 sharing
    @(negedge clk); ctl_pend = 1;
    idle(2);
    chk("R10 target yields", {30'd0, irq, irq_tgt}, 32'h2);
    @(negedge clk); ctl_pend = 0;
    idle(2);
    chk("R10 target reasserts", {30'd0, irq, irq_tgt}, 32'h3);
    wr(5, 32'h08);
    idle(2);
    chk("R10 line low", {30'd0, irq, irq_tgt}, 0);
    @(negedge clk); ctl_pend = 1;
    idle(2);
    chk("R10 controller only", {30'd0, irq, irq_tgt}, 32'h2);
    @(negedge clk); ctl_pend = 0;
    idle(2);

    // R11 DMA disabled
    wr(2, 0);
    wr(3, 200);
    wr(4, 4);
    d = wcount;
    bus_start(OWN);
    bus_byte(8'h33);
    bus_byte(8'h44);
    bus_stop();
    idle(2);
    chk("R11 no writes", wcount - d, 0);
    rd(3, d);
    chk("R11 address held", d, 200);

    finish_run();
  end
endmodule